// File: doc/BRIEF.md
# Programmable Interrupt Line Combiner

This block gathers thirty-two asynchronous interrupt request lines into one registered interrupt output for a host processor. Software sets it up through a small register window reached by single-cycle writes and combinational reads. For each line, software chooses three things: whether the line is enabled, whether it is level-sensitive or edge-captured, and whether it is asserted high or low. A read-only status register shows which enabled lines are requesting service right now.

Every input first passes through a two-flop synchronizer. It is then turned into an "active" signal according to its polarity bit. Level lines pass this active signal straight through. Edge lines latch each inactive-to-active transition. A latched edge is dismissed by writing a 1 to the line's bit in the dismiss register and then writing 0 again. Line 31 carries the request cascaded from a downstream legacy controller, and out of reset it is the only line treated as active high. Lines 20 to 30 have no source behind them, so the block keeps them permanently disabled.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable, trigger and dismiss registers read 0, the polarity register reads 0x8000_0000 (only line 31 active high), and irq_out is low.
- R2: The register window decodes bus_addr as follows: 0 is enable (1 = line enabled), 1 is trigger (1 = edge-captured, 0 = level), 2 is polarity (1 = active high, 0 = active low), 3 is dismiss, and 4 is status (read-only). A write takes effect at the clock edge where bus_we is 1. Writes to addresses 4 to 7 change nothing. Reads of addresses 5 to 7 return 0.
- R3: Lines 20 to 30 can never be enabled. Their bits read back as 0 at address 0 and are always 0 in the status register, whatever is written or driven.
- R4: On an enabled level line, the status bit equals the line's active state. It follows an input change after two clock edges.
- R5: On an enabled edge line, an inactive-to-active transition sets the status bit three clock edges after the input change. The bit stays set after the input returns to inactive.
- R6: While a line's dismiss bit is 1, its edge latch is held clear, and the status bit drops one clock edge after the dismiss write. Transitions that occur while the dismiss bit is 1 are lost. Edges are captured again once the bit returns to 0. Level lines ignore the dismiss register.
- R7: When a line is switched from edge to level, any latched edge is discarded, and the status bit follows the current level.
- R8: irq_out is the OR of all status bits, registered. It changes one clock edge after the status register does.
- R9: An active-low line (polarity bit 0) requests service while its input is 0 and is idle while its input is 1.
- R10: Line 31, the cascade line, behaves like any other line. With the reset polarity value, a high input on line 31 requests service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Asynchronous interrupt request lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The hardest case to reach is the interplay between a held dismiss bit and the edge latch. An input transition has to arrive while the dismiss bit is still 1, and then a second transition has to arrive after the bit returns to 0. This only happens when input toggles are timed against bus writes to within a cycle or two. Directed sequences build exactly that ordering. The random phase then mixes input toggles with writes to every register, including dismiss pulses and trigger flips on lines that already hold a latched edge. A cycle-level reference model checks every cycle against the stated latencies.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE   = 3'd0,
        REG_TRIGGER  = 3'd1,
        REG_POLARITY = 3'd2,
        REG_DISMISS  = 3'd3,
        REG_STATUS   = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] active,
    input  logic [WIDTH-1:0] edge_sel,
    input  logic [WIDTH-1:0] dismiss,
    output logic [WIDTH-1:0] latched
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] hold;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [WIDTH-1:0] rise;

    always_comb begin
        rise      = active & ~st_q.prev;
        st_d.prev = active;
        st_d.hold = (st_q.hold | (rise & edge_sel)) & edge_sel & ~dismiss;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched = st_q.hold;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES    = 32,
    parameter int SYNC_STAGES  = 2,
    parameter int DEAD_LO      = 20,
    parameter int DEAD_HI      = 30,
    parameter int CASCADE_LINE = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 irq_out
);

    function automatic logic [NUM_LINES-1:0] span_mask(input int lo, input int hi);
        logic [NUM_LINES-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NUM_LINES-1:0] DEAD_MASK = span_mask(DEAD_LO, DEAD_HI);
    localparam logic [NUM_LINES-1:0] POL_RESET = span_mask(CASCADE_LINE, CASCADE_LINE);

    typedef struct packed {
        logic [NUM_LINES-1:0] enable;
        logic [NUM_LINES-1:0] trigger;
        logic [NUM_LINES-1:0] polarity;
        logic [NUM_LINES-1:0] dismiss;
        logic                 irq;
    } ctl_state_t;

    ctl_state_t state_d, state_q;

    logic [NUM_LINES-1:0] sync_w;
    logic [NUM_LINES-1:0] active_w;
    logic [NUM_LINES-1:0] latch_w;
    logic [NUM_LINES-1:0] status_w;
    logic [NUM_LINES-1:0] trig_w;
    logic [NUM_LINES-1:0] dismiss_w;

    irq_sync_chain #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_w)
    );

    assign active_w  = ~(sync_w ^ state_q.polarity);
    assign trig_w    = state_q.trigger;
    assign dismiss_w = state_q.dismiss;

    irq_edge_bank #(
        .WIDTH (NUM_LINES)
    ) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active_w),
        .edge_sel (state_q.trigger),
        .dismiss  (state_q.dismiss),
        .latched  (latch_w)
    );

    always_comb begin
        status_w = ((state_q.trigger & latch_w) | (~state_q.trigger & active_w))
                   & state_q.enable & ~DEAD_MASK;

        state_d     = state_q;
        state_d.irq = |status_w;
        if (bus_we) begin
            case (reg_sel_e'(bus_addr))
                REG_ENABLE:   state_d.enable   = bus_wdata & ~DEAD_MASK;
                REG_TRIGGER:  state_d.trigger  = bus_wdata;
                REG_POLARITY: state_d.polarity = bus_wdata;
                REG_DISMISS:  state_d.dismiss  = bus_wdata;
                default:      ;
            endcase
        end

        case (reg_sel_e'(bus_addr))
            REG_ENABLE:   bus_rdata = state_q.enable;
            REG_TRIGGER:  bus_rdata = state_q.trigger;
            REG_POLARITY: bus_rdata = state_q.polarity;
            REG_DISMISS:  bus_rdata = state_q.dismiss;
            REG_STATUS:   bus_rdata = status_w;
            default:      bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.polarity <= POL_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_out = state_q.irq;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int                N         = 32,
    parameter logic [N-1:0]      DEAD_MASK = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   bus_addr,
    input logic [N-1:0] bus_rdata,
    input logic         irq_out,
    input logic [N-1:0] status,
    input logic [N-1:0] latch,
    input logic [N-1:0] trig,
    input logic [N-1:0] dismiss
);

    assert_irq_follows_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|status)));

    assert_dead_never_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status & DEAD_MASK) == '0);

    assert_dead_enable_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd0) |-> ((bus_rdata & DEAD_MASK) == '0));

    assert_dismiss_holds_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dismiss != '0) |=> ((latch & $past(dismiss)) == '0));

    assert_level_drops_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch & ~$past(trig)) == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .N         (NUM_LINES),
    .DEAD_MASK (DEAD_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .status    (status_w),
    .latch     (latch_w),
    .trig      (trig_w),
    .dismiss   (dismiss_w)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

    localparam logic [31:0] DEAD = 32'h7FF0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Reference model built from the stated latencies
    logic [31:0] m_s1, m_s2, m_prev, m_latch;
    logic [31:0] m_en, m_trig, m_pol, m_dis;
    logic        m_irq;

    function automatic logic [31:0] m_active();
        return ~(m_s2 ^ m_pol);
    endfunction

    function automatic logic [31:0] m_status();
        return ((m_trig & m_latch) | (~m_trig & m_active())) & m_en & ~DEAD;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_latch <= '0;
            m_en <= '0; m_trig <= '0; m_pol <= 32'h8000_0000; m_dis <= '0;
            m_irq <= 1'b0;
        end else begin
            m_s1    <= irq_in;
            m_s2    <= m_s1;
            m_prev  <= m_active();
            m_latch <= (m_latch | (m_active() & ~m_prev)) & m_trig & ~m_dis;
            m_irq   <= |m_status();
            if (bus_we) begin
                case (bus_addr)
                    3'd0: m_en   <= bus_wdata & ~DEAD;
                    3'd1: m_trig <= bus_wdata;
                    3'd2: m_pol  <= bus_wdata;
                    3'd3: m_dis  <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        // R1: reset values
        rd(3'd0, 32'h0, "R1 enable");
        rd(3'd1, 32'h0, "R1 trigger");
        rd(3'd2, 32'h8000_0000, "R1 polarity");
        rd(3'd3, 32'h0, "R1 dismiss");
        check("R1 irq_out", {31'd0, irq_out}, 32'd0);
        rst_n = 1'b1;
        tick(1);

        // R3: dead lines cannot be enabled
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 32'h800F_FFFF, "R3 enable readback");
        // R2: status and unused addresses ignore writes
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd0, 32'h800F_FFFF, "R2 enable untouched");
        rd(3'd1, 32'h0, "R2 trigger untouched");
        rd(3'd2, 32'h8000_0000, "R2 polarity untouched");
        rd(3'd3, 32'h0, "R2 dismiss untouched");
        rd(3'd5, 32'h0, "R2 unused reads zero");

        // all lines active high, level
        wr(3'd2, 32'hFFFF_FFFF);
        tick(3);
        rd(3'd4, 32'h0, "R4 idle status");

        // R4 and R8: level latency
        irq_in[3] = 1'b1;
        tick(1);
        rd(3'd4, 32'h0, "R4 one edge not visible");
        tick(1);
        rd(3'd4, 32'h0000_0008, "R4 level visible after two edges");
        check("R8 irq before register", {31'd0, irq_out}, 32'd0);
        tick(1);
        check("R8 irq one edge after status", {31'd0, irq_out}, 32'd1);
        irq_in[3] = 1'b0;
        tick(2);
        rd(3'd4, 32'h0, "R4 level released");
        tick(1);
        check("R8 irq drops", {31'd0, irq_out}, 32'd0);

        // R3: dead line driven
        irq_in[25] = 1'b1;
        tick(4);
        rd(3'd4, 32'h0, "R3 dead line status");
        check("R3 dead line irq", {31'd0, irq_out}, 32'd0);
        irq_in[25] = 1'b0;

        // R5: edge capture on line 5
        wr(3'd1, 32'h0000_0020);
        tick(3);
        irq_in[5] = 1'b1;
        tick(2);
        rd(3'd4, 32'h0, "R5 edge not yet latched");
        tick(1);
        rd(3'd4, 32'h0000_0020, "R5 edge latched after three edges");
        irq_in[5] = 1'b0;
        tick(4);
        rd(3'd4, 32'h0000_0020, "R5 latch persists");

        // R6: dismiss pulse and hold
        wr(3'd3, 32'h0000_0020);
        rd(3'd4, 32'h0000_0020, "R6 not yet cleared at write edge");
        tick(1);
        rd(3'd4, 32'h0, "R6 cleared one edge after write");
        irq_in[5] = 1'b1;
        tick(4);
        rd(3'd4, 32'h0, "R6 edge lost while dismiss held");
        irq_in[5] = 1'b0;
        wr(3'd3, 32'h0);
        tick(3);
        irq_in[5] = 1'b1;
        tick(4);
        rd(3'd4, 32'h0000_0020, "R6 edge captured after release");
        irq_in[5] = 1'b0;

        // R6: level line ignores dismiss
        irq_in[2] = 1'b1;
        wr(3'd3, 32'h0000_0004);
        tick(3);
        rd(3'd4, 32'h0000_0024, "R6 level line unaffected by dismiss");
        wr(3'd3, 32'h0);
        irq_in[2] = 1'b0;

        // R7: switching to level drops the latch
        wr(3'd1, 32'h0);
        tick(1);
        rd(3'd4, 32'h0, "R7 latch discarded on level switch");

        // R9: active-low line 7
        irq_in = 32'h0000_0080;
        wr(3'd2, 32'hFFFF_FF7F);
        tick(3);
        rd(3'd4, 32'h0, "R9 active-low idle when high");
        irq_in[7] = 1'b0;
        tick(2);
        rd(3'd4, 32'h0000_0080, "R9 active-low asserted when low");

        // R10: cascade line with reset polarity
        wr(3'd0, 32'h8000_0000);
        wr(3'd2, 32'h8000_0000);
        irq_in = 32'h7FFF_FFFF;
        tick(3);
        rd(3'd4, 32'h0, "R10 cascade idle");
        irq_in[31] = 1'b1;
        tick(2);
        rd(3'd4, 32'h8000_0000, "R10 cascade active high");
        tick(1);
        check("R10 cascade irq", {31'd0, irq_out}, 32'd1);

        // Random phase against the model
        void'($urandom(32'd1234));
        for (int cyc = 0; cyc < 4000; cyc++) begin
            bus_we = 1'b0; bus_addr = 3'd4;
            #1;
            check("R4/R5 random status", bus_rdata, m_status());
            check("R8 random irq", {31'd0, irq_out}, {31'd0, m_irq});
            if ($urandom_range(0, 3) == 0) begin
                irq_in = irq_in ^ (32'h1 << $urandom_range(0, 31));
            end
            if ($urandom_range(0, 9) == 0) begin
                bus_we    = 1'b1;
                bus_addr  = 3'($urandom_range(0, 5));
                bus_wdata = (bus_addr == 3'd3) ? ($urandom() & $urandom()) : $urandom();
            end
            tick(1);
        end
        bus_we = 1'b0;
        finish_run();
    end

endmodule